// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block collects eight interrupt request lines, keeps each request pending in a request register, and presents one interrupt line to a processor. A resolver picks the most urgent unmasked pending request. It does not signal that request if a source of equal or higher urgency is already being serviced. Each input has its own mask bit. A masked request stays pending and competes again once it is unmasked.

The processor answers with two acknowledge pulses. The first pulse moves the winning request from pending to in-service and holds the choice. During the second pulse the block drives an 8-bit type number: a programmable 5-bit base followed by the 3-bit input index. Software writes the mask, the base and the priority mode through a small write port, and ends service with an end-of-interrupt command. That command either names a level or clears the most urgent in-service level. In rotating mode the level just finished becomes the least urgent one, so no source is starved.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset no request is pending or in service, `int_o` and `type_oe_o` are low, the mask is 0, the base is 0 and the mode is fixed priority.
- R2: An input that is high at a clock edge sets its pending bit, and the bit stays set after the input falls. The request bit of the acknowledged input is cleared by the first acknowledge pulse, so with no other pending request `int_o` stays low after end-of-interrupt.
- R3: In fixed mode input 0 is the most urgent and input 7 the least urgent.
- R4: A write to address 0 sets the mask, where bit i masks input i. A masked pending request does not raise `int_o` but is kept, and clearing its mask bit raises `int_o` in the next cycle.
- R5: The first acknowledge pulse marks the winner in service and clears its pending bit. `int_o` stays low until the second pulse has ended.
- R6: `type_oe_o` is high only during the second acknowledge pulse, and `type_o` then equals {base, index}. The base is written with address 1 from data bits 7:3.
- R7: A pending request of equal or lower urgency than any in-service level does not raise `int_o`. A more urgent request does, so service can nest.
- R8: A write to address 3 with data bit 3 low is a non-specific end-of-interrupt. It clears only the most urgent in-service bit.
- R9: A write to address 3 with data bit 3 high clears the in-service bit of the level in data bits 2:0.
- R10: A write to address 2 with data bit 0 high selects rotating mode. After the end-of-interrupt of level L, L is the least urgent level and L+1 (mod 8) is the most urgent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 8 | Interrupt request lines, active high |
| ack_i | input | 1 | Acknowledge pulse from the processor |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 mask, 1 base, 2 mode, 3 end-of-interrupt |
| wr_data_i | input | 8 | Register write data |
| int_o | output | 1 | Interrupt to the processor |
| type_o | output | 8 | Type number, {base, index} |
| type_oe_o | output | 1 | Type number valid (second acknowledge pulse) |

## Verification
The bench sends simultaneous requests under several masks. A resolver that scanned in the wrong direction or ignored the mask would return the wrong index. It nests a more urgent source under a less urgent one and then ends service without naming a level. If the wrong in-service bit were cleared, the blocked low request would surface too early. It also checks that a request raised while its bit is masked survives until unmasked, which a design that dropped masked requests would lose. Rotating mode is checked by serving input 0 and then posting inputs 0 and 2 together: input 2 must win, where fixed priority would give input 0.

// File: rtl/pic_pkg.sv
package pic_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_WAIT = 1'b1
    } ack_ph_e;

    localparam logic [1:0] ADDR_MASK = 2'd0;
    localparam logic [1:0] ADDR_BASE = 2'd1;
    localparam logic [1:0] ADDR_MODE = 2'd2;
    localparam logic [1:0] ADDR_EOI  = 2'd3;

endpackage

// File: rtl/pic_resolver.sv
// Finds the most urgent set bit of a vector. Urgency starts just above
// the position held in low_i and wraps, so low_i itself is least urgent.
module pic_resolver #(
    parameter int N_IRQ = 8,
    parameter int IDX_W = $clog2(N_IRQ)
) (
    input  logic [N_IRQ-1:0] vec_i,
    input  logic [IDX_W-1:0] low_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [IDX_W-1:0] rank_o
);

    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        rank_o  = '0;
        // scan from least to most urgent so the most urgent hit is kept
        for (int k = N_IRQ - 1; k >= 0; k--) begin
            int pos;
            pos = (int'(low_i) + 1 + k) % N_IRQ;
            if (vec_i[pos]) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(pos);
                rank_o  = IDX_W'(k);
            end
        end
    end

endmodule

// File: rtl/pic_cfg.sv
// Holds mask, type base and priority mode written by software.
module pic_cfg
    import pic_pkg::*;
#(
    parameter int N_IRQ  = 8,
    parameter int TYPE_W = 8,
    parameter int BASE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [TYPE_W-1:0] wr_data_i,
    output logic [N_IRQ-1:0]  mask_o,
    output logic [BASE_W-1:0] base_o,
    output logic              rotate_o
);

    typedef struct packed {
        logic [N_IRQ-1:0]  mask;
        logic [BASE_W-1:0] base;
        logic              rotate;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            case (wr_addr_i)
                ADDR_MASK: cfg_d.mask   = wr_data_i[N_IRQ-1:0];
                ADDR_BASE: cfg_d.base   = wr_data_i[TYPE_W-1:TYPE_W-BASE_W];
                ADDR_MODE: cfg_d.rotate = wr_data_i[0];
                default:   cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mask_o   = cfg_q.mask;
    assign base_o   = cfg_q.base;
    assign rotate_o = cfg_q.rotate;

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int N_IRQ  = 8,
    parameter int TYPE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IRQ-1:0]  irq_req_i,
    input  logic              ack_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [TYPE_W-1:0] wr_data_i,
    output logic              int_o,
    output logic [TYPE_W-1:0] type_o,
    output logic              type_oe_o
);

    localparam int IDX_W  = $clog2(N_IRQ);
    localparam int BASE_W = TYPE_W - IDX_W;

    typedef struct packed {
        logic [N_IRQ-1:0] irr;
        logic [N_IRQ-1:0] isr;
        logic [IDX_W-1:0] low;
        ack_ph_e          ph;
        logic [IDX_W-1:0] sel;
    } core_t;

    core_t st_d, st_q;

    logic [N_IRQ-1:0]  mask_q;
    logic [BASE_W-1:0] base_q;
    logic              rot_q;

    pic_cfg #(
        .N_IRQ (N_IRQ),
        .TYPE_W(TYPE_W),
        .BASE_W(BASE_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en_i),
        .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i),
        .mask_o   (mask_q),
        .base_o   (base_q),
        .rotate_o (rot_q)
    );

    // least urgent position: fixed mode pins it to the top index
    logic [IDX_W-1:0] low_ptr;
    assign low_ptr = rot_q ? st_q.low : IDX_W'(N_IRQ - 1);

    logic             req_valid, isr_valid;
    logic [IDX_W-1:0] req_idx, req_rank, isr_idx, isr_rank;

    pic_resolver #(.N_IRQ(N_IRQ), .IDX_W(IDX_W)) u_req_res (
        .vec_i  (st_q.irr & ~mask_q),
        .low_i  (low_ptr),
        .valid_o(req_valid),
        .idx_o  (req_idx),
        .rank_o (req_rank)
    );

    pic_resolver #(.N_IRQ(N_IRQ), .IDX_W(IDX_W)) u_isr_res (
        .vec_i  (st_q.isr),
        .low_i  (low_ptr),
        .valid_o(isr_valid),
        .idx_o  (isr_idx),
        .rank_o (isr_rank)
    );

    logic             win_ok;
    logic             eoi_wr;
    logic             eoi_spec;
    logic [IDX_W-1:0] eoi_tgt;

    assign win_ok   = req_valid && (!isr_valid || (req_rank < isr_rank));
    assign eoi_wr   = wr_en_i && (wr_addr_i == ADDR_EOI);
    assign eoi_spec = wr_data_i[IDX_W];
    assign eoi_tgt  = eoi_spec ? wr_data_i[IDX_W-1:0] : isr_idx;

    always_comb begin
        st_d     = st_q;
        st_d.irr = st_q.irr | irq_req_i;

        if (ack_i) begin
            if (st_q.ph == PH_IDLE) begin
                st_d.ph = PH_WAIT;
                if (win_ok) begin
                    st_d.isr[req_idx] = 1'b1;
                    st_d.irr[req_idx] = 1'b0;
                    st_d.sel          = req_idx;
                end else begin
                    st_d.sel = IDX_W'(N_IRQ - 1);
                end
            end else begin
                st_d.ph = PH_IDLE;
            end
        end

        if (eoi_wr && (eoi_spec || isr_valid)) begin
            st_d.isr[eoi_tgt] = 1'b0;
            if (rot_q) begin
                st_d.low = eoi_tgt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.irr <= '0;
            st_q.isr <= '0;
            st_q.low <= IDX_W'(N_IRQ - 1);
            st_q.ph  <= PH_IDLE;
            st_q.sel <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign int_o     = (st_q.ph == PH_IDLE) && win_ok;
    assign type_oe_o = ack_i && (st_q.ph == PH_WAIT);
    assign type_o    = {base_q, st_q.sel};

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
    parameter int N_IRQ = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack_i,
    input logic             int_o,
    input logic             type_oe_o,
    input logic             eoi_wr,
    input logic [N_IRQ-1:0] irr,
    input logic [N_IRQ-1:0] isr,
    input logic [N_IRQ-1:0] mask
);

    AST_TYPE_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        type_oe_o |-> ack_i); // R6

    AST_INT_DROPS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (int_o && ack_i) |=> !int_o); // R5

    AST_ISR_GROWS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (int_o && ack_i && !eoi_wr) |=> ($countones(isr) == $countones($past(isr)) + 1)); // R5

    AST_ONE_NEW_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(isr & ~$past(isr))); // R5

    AST_NO_INT_DURING_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
        type_oe_o |-> !int_o); // R5

    AST_INT_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        int_o |-> ((irr & ~mask) != '0)); // R4

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N_IRQ(N_IRQ)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack_i    (ack_i),
    .int_o    (int_o),
    .type_oe_o(type_oe_o),
    .eoi_wr   (eoi_wr),
    .irr      (st_q.irr),
    .isr      (st_q.isr),
    .mask     (mask_q)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_req = '0;
    logic       ack = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       int_o;
    logic [7:0] type_o;
    logic       type_oe;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_irq_ctrl u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_req_i(irq_req),
        .ack_i    (ack),
        .wr_en_i  (wr_en),
        .wr_addr_i(wr_addr),
        .wr_data_i(wr_data),
        .int_o    (int_o),
        .type_o   (type_o),
        .type_oe_o(type_oe)
    );

    // {requests, mask, expect int, expect index}; base 0x40, fixed mode
    localparam logic [31:0] VEC [8] = '{
        {8'h01, 8'h00, 8'h01, 8'h00},
        {8'h80, 8'h00, 8'h01, 8'h07},
        {8'h0C, 8'h00, 8'h01, 8'h02},
        {8'hF0, 8'h10, 8'h01, 8'h05},
        {8'hFF, 8'hFF, 8'h00, 8'h00},
        {8'h24, 8'h04, 8'h01, 8'h05},
        {8'h00, 8'h00, 8'h00, 8'h00},
        {8'hA0, 8'h80, 8'h01, 8'h05}
    };

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic do_reset();
        rst_n = 1'b0;
        irq_req = '0; ack = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_req(input logic [7:0] v);
        irq_req = v;
        @(negedge clk);
        irq_req = '0;
    endtask

    task automatic ack_seq(output logic [7:0] ty, output logic oe);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        @(negedge clk);
        ack = 1'b1;
        #1;
        ty = type_o;
        oe = type_oe;
        @(negedge clk);
        ack = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    initial begin
        logic [7:0] ty;
        logic       oe;

        // R1 reset state
        do_reset();
        chk("R1 int after reset", {7'd0, int_o}, 8'h00);
        chk("R1 type_oe after reset", {7'd0, type_oe}, 8'h00);
        pulse_req(8'h04);
        chk("R2 latched request raises int", {7'd0, int_o}, 8'h01);
        ack_seq(ty, oe);
        chk("R1 base zero after reset", ty, 8'h02);
        chk("R6 type_oe on second pulse", {7'd0, oe}, 8'h01);
        chk("R6 type_oe low after pulse", {7'd0, type_oe}, 8'h00);

        // R3 R4 R6 table walk
        for (int i = 0; i < 8; i++) begin
            do_reset();
            wr(2'd1, 8'h40);
            wr(2'd0, VEC[i][23:16]);
            pulse_req(VEC[i][31:24]);
            chk("R4 int after requests", {7'd0, int_o}, VEC[i][15:8]);
            if (VEC[i][8]) begin
                ack_seq(ty, oe);
                chk("R3 type for winner", ty, 8'h40 | VEC[i][7:0]);
            end
        end

        // R5 R7 R8 R9 nesting
        do_reset();
        wr(2'd1, 8'h40);
        pulse_req(8'h10);
        ack_seq(ty, oe);
        chk("R5 first service type", ty, 8'h44);
        chk("R5 int low after service", {7'd0, int_o}, 8'h00);
        pulse_req(8'h40);
        chk("R7 lower request blocked", {7'd0, int_o}, 8'h00);
        pulse_req(8'h02);
        chk("R7 higher request nests", {7'd0, int_o}, 8'h01);
        ack_seq(ty, oe);
        chk("R7 nested type", ty, 8'h41);
        chk("R7 still blocked", {7'd0, int_o}, 8'h00);
        wr(2'd3, 8'h00);
        chk("R8 nonspecific clears level 1 only", {7'd0, int_o}, 8'h00);
        wr(2'd3, 8'h00);
        chk("R8 second nonspecific clears level 4", {7'd0, int_o}, 8'h01);
        ack_seq(ty, oe);
        chk("R8 released request type", ty, 8'h46);
        pulse_req(8'h80);
        chk("R7 level 7 blocked by 6", {7'd0, int_o}, 8'h00);
        wr(2'd3, 8'h0E);
        chk("R9 specific eoi level 6", {7'd0, int_o}, 8'h01);
        ack_seq(ty, oe);
        chk("R9 type after specific", ty, 8'h47);
        wr(2'd3, 8'h0F);
        chk("R2 request gone after ack", {7'd0, int_o}, 8'h00);

        // R4 masked request kept
        do_reset();
        wr(2'd0, 8'h08);
        pulse_req(8'h08);
        chk("R4 masked no int", {7'd0, int_o}, 8'h00);
        wr(2'd0, 8'h00);
        chk("R4 unmask raises int", {7'd0, int_o}, 8'h01);

        // R10 rotating
        do_reset();
        wr(2'd1, 8'h40);
        wr(2'd2, 8'h01);
        pulse_req(8'h01);
        ack_seq(ty, oe);
        chk("R10 first rotate type", ty, 8'h40);
        wr(2'd3, 8'h00);
        pulse_req(8'h05);
        ack_seq(ty, oe);
        chk("R10 served input now lowest", ty, 8'h42);
        wr(2'd3, 8'h00);
        chk("R10 pending 0 after rotate", {7'd0, int_o}, 8'h01);
        ack_seq(ty, oe);
        chk("R10 input 0 served last", ty, 8'h40);

        // R6 base field
        do_reset();
        wr(2'd1, 8'hF8);
        pulse_req(8'h08);
        ack_seq(ty, oe);
        chk("R6 full base", ty, 8'hFB);

        finish_run();
    end

endmodule